// File: doc/BRIEF.md
# Embedded-Controller Link Slave Byte Sequencer

This block sits behind an I2C slave front end on a link where an embedded controller is the bus master. The front end hands over one event per bus byte. Each event carries the byte it received and four flags: interrupt, address-received, read-not-write and end-of-transfer. The sequencer follows each transfer through five states. It stores what the master writes in an incoming buffer, and it answers read events with the bytes of an outgoing message.

A transfer becomes a slave transmit only when the master turns the bus round straight after the command byte 0x01. Every other transfer is a receive. The local side fills the outgoing payload buffer and then posts the payload length. This drives an active-low request line, which asks the master to come and read. The message goes out as a length byte followed by the payload. If the master stops early, the whole message is sent again. If the master reads while nothing is posted, a fixed no-op message is returned.

Top module: `ec_link_seq`

## Requirements
- R1: After a synchronous active-high reset, req_n is 1, tx_pending is 0, resp_valid and rx_done are 0, and all four error flags are 0.
- R2: A start event (irq and address-received set, read and end clear) moves the block to expect-command. If ev_byte differs from cfg_addr, err_addr is set and stays set, but the transfer still goes on.
- R3: In a receive, the command byte is stored at index 0 and the following data bytes at the next indices. An end event without the read flag gives a one-cycle rx_done, one cycle after that event, with rx_count equal to the number of bytes stored.
- R4: A receive stores at most RX_MAX bytes. Later data bytes are dropped and set the sticky err_ovf, and rx_count reports RX_MAX.
- R5: After command 0x01, an event with irq, read and address-received set starts a transmit. The responses are the length byte and then each payload byte in order. An end event that arrives after every byte has gone clears tx_pending.
- R6: If nothing is posted when a transmit starts, the responses are 0x02, 0x07, 0x02.
- R7: Posting a message drives req_n low in the next cycle. req_n returns to 1 in the cycle in which the first transmit byte is supplied.
- R8: An end event during a transmit that comes before all bytes have gone rewinds the message and drives req_n low again. tx_pending stays 1, and the next transmit starts again from the length byte.
- R9: A read event after the last byte of a transmit sets the sticky err_udf, responds 0xFF and returns to idle.
- R10: A turnaround read after any command other than 0x01 sets the sticky err_flag, responds 0xFF and returns to idle. Later data and end events then give no rx_done.
- R11: In expect-command, an event that is not a plain irq event sets err_flag and returns to idle, so the transfer gives no rx_done.
- R12: A response (resp_valid for one cycle, one cycle after the event) comes only for an irq event that has the read flag set and the end flag clear. Write events get no response.
- R13: An event whose irq flag is clear has no effect: there is no response, nothing is stored, and the count does not change.
- R14: While tx_pending is 1, payload writes and further posts are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 8 | Expected 8-bit address byte |
| ev_valid | input | 1 | One bus-byte event this cycle |
| ev_byte | input | 8 | Byte received with the event |
| ev_irq | input | 1 | Interrupt flag of the event |
| ev_addr | input | 1 | Address-received (start) flag |
| ev_rnw | input | 1 | Read-not-write flag |
| ev_end | input | 1 | End-of-transfer flag |
| resp_valid | output | 1 | A response byte is presented |
| resp_byte | output | 8 | Byte to drive on the read |
| req_n | output | 1 | Active-low request line to the master |
| tx_wr_en | input | 1 | Write one outgoing payload byte |
| tx_wr_idx | input | $clog2(TX_MAX) | Payload byte index |
| tx_wr_byte | input | 8 | Payload byte value |
| tx_post | input | 1 | Post the payload as a message |
| tx_len | input | $clog2(TX_MAX+1) | Payload length for the post |
| tx_pending | output | 1 | A posted message has not been fully sent |
| rx_done | output | 1 | One-cycle pulse: a receive finished |
| rx_count | output | $clog2(RX_MAX+1) | Bytes stored by the finished receive |
| rx_rd_idx | input | $clog2(RX_MAX) | Incoming buffer read index |
| rx_rd_byte | output | 8 | Incoming buffer byte at rx_rd_idx |
| err_addr | output | 1 | Sticky address mismatch |
| err_flag | output | 1 | Sticky unexpected flag combination |
| err_ovf | output | 1 | Sticky receive overflow |
| err_udf | output | 1 | Sticky transmit underflow |

## Verification
The assertions check the invariants that hold on every cycle. A response appears only after a read event that is not an end event. Events without irq produce nothing. rx_done follows only a write-side end event, and the reported count never exceeds RX_MAX. A post raises tx_pending and lowers req_n, req_n is released only together with a first-byte response, and tx_pending and err_ovf do not drop on their own. The exact byte sequences need the bench's scenarios: length-prefixed payloads, the no-op fill, the resend after an early stop, the fill byte on underflow and on a refused turnaround, and the buffer contents after an overflow.

// File: rtl/ec_link_pkg.sv
package ec_link_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMD   = 3'd1,
        ST_FIRST = 3'd2,
        ST_TX    = 3'd3,
        ST_RX    = 3'd4
    } seq_st_e;

    localparam logic [7:0] FILL_BYTE  = 8'hFF;
    localparam logic [7:0] CMD_READ   = 8'h01;
    localparam logic [7:0] NOOP_LEN   = 8'h02;
    localparam logic [7:0] NOOP_BODY0 = 8'h07;
    localparam logic [7:0] NOOP_BODY1 = 8'h02;
    localparam int         NOOP_SIZE  = 3;

endpackage

// File: rtl/ec_link_evdec.sv
module ec_link_evdec (
    input  logic ev_valid,
    input  logic ev_irq,
    input  logic ev_addr,
    input  logic ev_rnw,
    input  logic ev_end,
    output logic act,
    output logic k_start,
    output logic k_plain,
    output logic k_rdfirst,
    output logic f_new,
    output logic f_read,
    output logic f_end,
    output logic f_rnw,
    output logic f_rcvd
);
    // flags only count when the event is live and carries irq
    always_comb begin
        act       = ev_valid && ev_irq;
        k_start   = act && ev_addr && !ev_rnw && !ev_end;
        k_plain   = act && !ev_addr && !ev_rnw && !ev_end;
        k_rdfirst = act && ev_addr && ev_rnw && !ev_end;
        f_new     = act && ev_addr && !ev_rnw;
        f_read    = act && ev_rnw && !ev_end;
        f_end     = ev_end;
        f_rnw     = ev_rnw;
        f_rcvd    = ev_addr;
    end
endmodule

// File: rtl/ec_link_txbuf.sv
module ec_link_txbuf #(
    parameter int TX_MAX = 32,
    localparam int TXA_W = $clog2(TX_MAX),
    localparam int TXL_W = $clog2(TX_MAX + 1),
    localparam int TXI_W = $clog2(TX_MAX + 2)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [TXA_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic [TXL_W-1:0] len,
    input  logic             noop,
    input  logic [TXI_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);
    import ec_link_pkg::*;

    logic [TX_MAX-1:0][7:0] cells;

    for (genvar i = 0; i < TX_MAX; i++) begin : g_cell
        logic [7:0] cell_q;
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == TXA_W'(i)) begin
                cell_q <= wr_byte;
            end
        end
        assign cells[i] = cell_q;
    end

    logic [TXI_W-1:0] body_idx;
    logic             body_ok;

    always_comb begin
        body_idx = rd_idx - TXI_W'(1);
        body_ok  = (rd_idx != '0) && (rd_idx <= TXI_W'(len))
                   && ({1'b0, body_idx} < (TXI_W + 1)'(TX_MAX));
        rd_byte  = FILL_BYTE;
        if (noop) begin
            case (rd_idx)
                TXI_W'(0): rd_byte = NOOP_LEN;
                TXI_W'(1): rd_byte = NOOP_BODY0;
                TXI_W'(2): rd_byte = NOOP_BODY1;
                default:   rd_byte = FILL_BYTE;
            endcase
        end else if (rd_idx == '0) begin
            rd_byte = 8'(len);
        end else if (body_ok) begin
            rd_byte = cells[TXA_W'(body_idx)];
        end
    end
endmodule

// File: rtl/ec_link_rxbuf.sv
module ec_link_rxbuf #(
    parameter int RX_MAX = 32,
    localparam int RXA_W = $clog2(RX_MAX)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [RXA_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic [RXA_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);
    logic [RX_MAX-1:0][7:0] cells;

    for (genvar i = 0; i < RX_MAX; i++) begin : g_cell
        logic [7:0] cell_q;
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == RXA_W'(i)) begin
                cell_q <= wr_byte;
            end
        end
        assign cells[i] = cell_q;
    end

    always_comb begin
        if ({1'b0, rd_idx} < (RXA_W + 1)'(RX_MAX)) begin
            rd_byte = cells[rd_idx];
        end else begin
            rd_byte = 8'h00;
        end
    end
endmodule

// File: rtl/ec_link_seq.sv
module ec_link_seq #(
    parameter int TX_MAX = 32,
    parameter int RX_MAX = 32,
    localparam int TXA_W = $clog2(TX_MAX),
    localparam int TXL_W = $clog2(TX_MAX + 1),
    localparam int TXI_W = $clog2(TX_MAX + 2),
    localparam int RXA_W = $clog2(RX_MAX),
    localparam int RXP_W = $clog2(RX_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       cfg_addr,
    input  logic             ev_valid,
    input  logic [7:0]       ev_byte,
    input  logic             ev_irq,
    input  logic             ev_addr,
    input  logic             ev_rnw,
    input  logic             ev_end,
    output logic             resp_valid,
    output logic [7:0]       resp_byte,
    output logic             req_n,
    input  logic             tx_wr_en,
    input  logic [TXA_W-1:0] tx_wr_idx,
    input  logic [7:0]       tx_wr_byte,
    input  logic             tx_post,
    input  logic [TXL_W-1:0] tx_len,
    output logic             tx_pending,
    output logic             rx_done,
    output logic [RXP_W-1:0] rx_count,
    input  logic [RXA_W-1:0] rx_rd_idx,
    output logic [7:0]       rx_rd_byte,
    output logic             err_addr,
    output logic             err_flag,
    output logic             err_ovf,
    output logic             err_udf
);
    import ec_link_pkg::*;

    typedef struct packed {
        seq_st_e          st;
        logic [RXP_W-1:0] rx_pos;
        logic [7:0]       rx_cmd;
        logic [TXI_W-1:0] tx_pos;
        logic             tx_noop;
        logic             pending;
        logic [TXL_W-1:0] tx_len;
        logic             req_n;
        logic             resp_valid;
        logic [7:0]       resp_byte;
        logic             done;
        logic [RXP_W-1:0] done_cnt;
        logic             e_addr;
        logic             e_flag;
        logic             e_ovf;
        logic             e_udf;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        st:         ST_IDLE,
        rx_pos:     '0,
        rx_cmd:     '0,
        tx_pos:     '0,
        tx_noop:    1'b0,
        pending:    1'b0,
        tx_len:     '0,
        req_n:      1'b1,
        resp_valid: 1'b0,
        resp_byte:  FILL_BYTE,
        done:       1'b0,
        done_cnt:   '0,
        e_addr:     1'b0,
        e_flag:     1'b0,
        e_ovf:      1'b0,
        e_udf:      1'b0
    };

    seq_t q, d;

    // event classification
    logic act, k_start, k_plain, k_rdfirst, f_new, f_read, f_end, f_rnw, f_rcvd;

    ec_link_evdec u_evdec (
        .ev_valid  (ev_valid),
        .ev_irq    (ev_irq),
        .ev_addr   (ev_addr),
        .ev_rnw    (ev_rnw),
        .ev_end    (ev_end),
        .act       (act),
        .k_start   (k_start),
        .k_plain   (k_plain),
        .k_rdfirst (k_rdfirst),
        .f_new     (f_new),
        .f_read    (f_read),
        .f_end     (f_end),
        .f_rnw     (f_rnw),
        .f_rcvd    (f_rcvd)
    );

    // outgoing buffer: one read port, selected by state
    logic [TXI_W-1:0] tx_rd_idx;
    logic             tx_rd_noop;
    logic [7:0]       tx_rd_byte;
    logic             tx_we;

    ec_link_txbuf #(.TX_MAX(TX_MAX)) u_txbuf (
        .clk     (clk),
        .wr_en   (tx_we),
        .wr_idx  (tx_wr_idx),
        .wr_byte (tx_wr_byte),
        .len     (q.tx_len),
        .noop    (tx_rd_noop),
        .rd_idx  (tx_rd_idx),
        .rd_byte (tx_rd_byte)
    );

    // incoming buffer
    logic             rx_we;
    logic [RXA_W-1:0] rx_wi;

    ec_link_rxbuf #(.RX_MAX(RX_MAX)) u_rxbuf (
        .clk     (clk),
        .wr_en   (rx_we),
        .wr_idx  (rx_wi),
        .wr_byte (ev_byte),
        .rd_idx  (rx_rd_idx),
        .rd_byte (rx_rd_byte)
    );

    logic [TXI_W-1:0] tx_size;
    logic [7:0]       to_send;
    seq_st_e          st_eff;

    always_comb begin
        d            = q;
        d.resp_valid = 1'b0;
        d.resp_byte  = FILL_BYTE;
        d.done       = 1'b0;
        rx_we        = 1'b0;
        rx_wi        = RXA_W'(q.rx_pos);
        to_send      = FILL_BYTE;
        st_eff       = q.st;
        tx_we        = tx_wr_en && !q.pending;

        if (q.st == ST_TX) begin
            tx_rd_idx  = q.tx_pos;
            tx_rd_noop = q.tx_noop;
        end else begin
            tx_rd_idx  = '0;
            tx_rd_noop = !q.pending;
        end

        if (q.tx_noop) begin
            tx_size = TXI_W'(NOOP_SIZE);
        end else begin
            tx_size = TXI_W'(q.tx_len) + TXI_W'(1);
        end

        if (act) begin
            if (k_start) begin
                st_eff = ST_IDLE;
            end
            d.st = st_eff;

            case (st_eff)
                ST_IDLE: begin
                    if (!k_start) begin
                        d.e_flag = 1'b1;
                    end
                end
                ST_CMD: begin
                    if (!k_plain) begin
                        d.e_flag = 1'b1;
                        d.st     = ST_IDLE;
                    end else begin
                        rx_we    = 1'b1;
                        rx_wi    = '0;
                        d.rx_cmd = ev_byte;
                        d.rx_pos = RXP_W'(1);
                        d.st     = ST_FIRST;
                    end
                end
                ST_FIRST: begin
                    if (k_rdfirst) begin
                        if (q.rx_cmd != CMD_READ) begin
                            d.e_flag = 1'b1;
                            d.st     = ST_IDLE;
                        end else begin
                            d.st      = ST_TX;
                            d.tx_noop = !q.pending;
                            d.tx_pos  = TXI_W'(1);
                            to_send   = tx_rd_byte;
                        end
                    end else if (k_plain) begin
                        rx_we    = 1'b1;
                        rx_wi    = RXA_W'(1);
                        d.rx_pos = RXP_W'(2);
                        d.st     = ST_RX;
                    end else begin
                        d.e_flag = 1'b1;
                        d.st     = ST_IDLE;
                    end
                end
                ST_TX: begin
                    if (f_end) begin
                        if (q.tx_pos != tx_size) begin
                            d.tx_pos = '0;
                            d.req_n  = 1'b0;
                        end else begin
                            d.st = ST_IDLE;
                            if (!q.tx_noop) begin
                                d.pending = 1'b0;
                            end
                        end
                    end else if (!f_rnw || f_rcvd) begin
                        d.e_flag = 1'b1;
                        d.st     = ST_IDLE;
                    end else if (q.tx_pos < tx_size) begin
                        to_send  = tx_rd_byte;
                        d.tx_pos = q.tx_pos + TXI_W'(1);
                    end else begin
                        d.e_udf = 1'b1;
                        d.st    = ST_IDLE;
                    end
                end
                ST_RX: begin
                    if (f_end && !f_rnw) begin
                        d.done     = 1'b1;
                        d.done_cnt = q.rx_pos;
                        d.st       = ST_IDLE;
                    end else if (f_rnw || f_rcvd) begin
                        d.e_flag = 1'b1;
                        d.st     = ST_IDLE;
                    end else if (q.rx_pos < RXP_W'(RX_MAX)) begin
                        rx_we    = 1'b1;
                        d.rx_pos = q.rx_pos + RXP_W'(1);
                    end else begin
                        d.e_ovf = 1'b1;
                    end
                end
                default: begin
                    d.st = ST_IDLE;
                end
            endcase

            // a freshly addressed write always opens a new transfer
            if (f_new) begin
                if (ev_byte != cfg_addr) begin
                    d.e_addr = 1'b1;
                end
                d.st = ST_CMD;
            end

            if (f_read) begin
                d.resp_valid = 1'b1;
                d.resp_byte  = to_send;
            end

            if (k_rdfirst) begin
                d.req_n = 1'b1;
            end
        end

        if (tx_post && !q.pending) begin
            d.pending = 1'b1;
            d.tx_len  = tx_len;
            d.req_n   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= SEQ_RESET;
        end else begin
            q <= d;
        end
    end

    assign resp_valid = q.resp_valid;
    assign resp_byte  = q.resp_byte;
    assign req_n      = q.req_n;
    assign tx_pending = q.pending;
    assign rx_done    = q.done;
    assign rx_count   = q.done_cnt;
    assign err_addr   = q.e_addr;
    assign err_flag   = q.e_flag;
    assign err_ovf    = q.e_ovf;
    assign err_udf    = q.e_udf;

endmodule

// File: rtl/ec_link_seq_chk.sv
module ec_link_seq_chk #(
    parameter int RX_MAX = 32,
    localparam int RXP_W = $clog2(RX_MAX + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             ev_valid,
    input logic             ev_irq,
    input logic             ev_addr,
    input logic             ev_rnw,
    input logic             ev_end,
    input logic             resp_valid,
    input logic             req_n,
    input logic             tx_post,
    input logic             tx_pending,
    input logic             rx_done,
    input logic [RXP_W-1:0] rx_count,
    input logic             err_ovf
);
    p_resp_on_read_r12: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(ev_valid && ev_irq && ev_rnw && !ev_end));

    p_noirq_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !ev_irq) |=> (!resp_valid && !rx_done));

    p_done_after_end_r3: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> $past(ev_valid && ev_irq && ev_end && !ev_rnw));

    p_count_cap_r4: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> (rx_count <= RXP_W'(RX_MAX)));

    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        err_ovf |=> err_ovf);

    p_release_first_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(req_n) |-> (resp_valid && $past(ev_addr && ev_rnw)));

    p_post_requests_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_post && !tx_pending) |=> (tx_pending && !req_n));

    p_pending_hold_r14: assert property (@(posedge clk) disable iff (rst)
        (tx_pending && !ev_valid) |=> tx_pending);
endmodule

bind ec_link_seq ec_link_seq_chk #(.RX_MAX(RX_MAX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ev_valid   (ev_valid),
    .ev_irq     (ev_irq),
    .ev_addr    (ev_addr),
    .ev_rnw     (ev_rnw),
    .ev_end     (ev_end),
    .resp_valid (resp_valid),
    .req_n      (req_n),
    .tx_post    (tx_post),
    .tx_pending (tx_pending),
    .rx_done    (rx_done),
    .rx_count   (rx_count),
    .err_ovf    (err_ovf)
);

// File: tb/tb_ec_link_seq.sv
module tb_ec_link_seq;
    localparam int TXM = 8;
    localparam int RXM = 8;
    localparam logic [7:0] ADDR = 8'h8A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_valid = 0, ev_irq = 0, ev_addr = 0, ev_rnw = 0, ev_end = 0;
    logic [7:0] ev_byte = 0;
    logic       resp_valid;
    logic [7:0] resp_byte;
    logic       req_n;
    logic       tx_wr_en = 0;
    logic [2:0] tx_wr_idx = 0;
    logic [7:0] tx_wr_byte = 0;
    logic       tx_post = 0;
    logic [3:0] tx_len = 0;
    logic       tx_pending;
    logic       rx_done;
    logic [3:0] rx_count;
    logic [2:0] rx_rd_idx = 0;
    logic [7:0] rx_rd_byte;
    logic       err_addr, err_flag, err_ovf, err_udf;

    ec_link_seq #(.TX_MAX(TXM), .RX_MAX(RXM)) dut (
        .clk(clk), .rst(rst), .cfg_addr(ADDR),
        .ev_valid(ev_valid), .ev_byte(ev_byte), .ev_irq(ev_irq),
        .ev_addr(ev_addr), .ev_rnw(ev_rnw), .ev_end(ev_end),
        .resp_valid(resp_valid), .resp_byte(resp_byte), .req_n(req_n),
        .tx_wr_en(tx_wr_en), .tx_wr_idx(tx_wr_idx), .tx_wr_byte(tx_wr_byte),
        .tx_post(tx_post), .tx_len(tx_len), .tx_pending(tx_pending),
        .rx_done(rx_done), .rx_count(rx_count),
        .rx_rd_idx(rx_rd_idx), .rx_rd_byte(rx_rd_byte),
        .err_addr(err_addr), .err_flag(err_flag),
        .err_ovf(err_ovf), .err_udf(err_udf)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int done_seen = 0;
    int last_cnt = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (resp_valid) begin
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_err++;
                    $display("FAIL R12 unexpected response: actual=0x%0h expected=none", resp_byte);
                end else begin
                    chk(tag_q.pop_front(), int'(resp_byte), int'(exp_q.pop_front()));
                end
            end
            if (rx_done) begin
                done_seen++;
                last_cnt = int'(rx_count);
            end
        end
    end

    task automatic expect_rsp(input logic [7:0] b, input string tag);
        exp_q.push_back(b);
        tag_q.push_back(tag);
    endtask

    task automatic ev(input logic [7:0] b, input logic irq, input logic ad,
                      input logic rnw, input logic en);
        ev_valid = 1; ev_byte = b; ev_irq = irq; ev_addr = ad; ev_rnw = rnw; ev_end = en;
        @(posedge clk);
        #1;
        ev_valid = 0; ev_byte = 0; ev_irq = 0; ev_addr = 0; ev_rnw = 0; ev_end = 0;
    endtask

    task automatic ev_start(input logic [7:0] b); ev(b, 1, 1, 0, 0); endtask
    task automatic ev_plain(input logic [7:0] b); ev(b, 1, 0, 0, 0); endtask
    task automatic ev_rdfirst();                  ev(8'h00, 1, 1, 1, 0); endtask
    task automatic ev_rd();                       ev(8'h00, 1, 0, 1, 0); endtask
    task automatic ev_wend();                     ev(8'h00, 1, 0, 0, 1); endtask
    task automatic ev_rend();                     ev(8'h00, 1, 0, 1, 1); endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic drain(input string tag);
        chk(tag, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic wr(input int idx, input logic [7:0] b);
        tx_wr_en = 1; tx_wr_idx = 3'(idx); tx_wr_byte = b;
        @(posedge clk);
        #1;
        tx_wr_en = 0;
    endtask

    task automatic post(input int len);
        tx_post = 1; tx_len = 4'(len);
        @(posedge clk);
        #1;
        tx_post = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
    endtask

    task automatic rx_at(input int idx, input logic [7:0] b, input string tag);
        rx_rd_idx = 3'(idx);
        #1;
        chk(tag, int'(rx_rd_byte), int'(b));
    endtask

    initial begin
        int d0;
        do_reset();
        settle();
        // R1 reset state
        chk("R1 req_n", int'(req_n), 1);
        chk("R1 tx_pending", int'(tx_pending), 0);
        chk("R1 resp_valid", int'(resp_valid), 0);
        chk("R1 errors", int'({err_addr, err_flag, err_ovf, err_udf}), 0);

        // R3 / R12 / R13: receive with a no-irq event in the middle
        d0 = done_seen;
        ev_start(ADDR);
        ev_plain(8'h05);
        ev_plain(8'h03);
        ev(8'h5A, 0, 0, 1, 0);   // no irq: ignored (R13)
        ev_plain(8'hAA);
        ev(8'h5B, 0, 1, 0, 1);   // no irq: ignored (R13)
        ev_plain(8'hBB);
        ev_plain(8'hCC);
        ev_wend();
        settle();
        chk("R3 done pulses", done_seen - d0, 1);
        chk("R3 R13 count", last_cnt, 5);
        rx_at(0, 8'h05, "R3 byte0");
        rx_at(1, 8'h03, "R3 byte1");
        rx_at(2, 8'hAA, "R13 byte2");
        rx_at(4, 8'hCC, "R3 byte4");
        chk("R2 no addr error", int'(err_addr), 0);
        drain("R12 no response on writes");

        // R2 address mismatch still proceeds
        d0 = done_seen;
        ev_start(8'h44);
        ev_plain(8'h06);
        ev_plain(8'h00);
        ev_wend();
        settle();
        chk("R2 err_addr", int'(err_addr), 1);
        chk("R2 done", done_seen - d0, 1);
        chk("R2 count", last_cnt, 2);

        // R4 overflow
        d0 = done_seen;
        ev_start(ADDR);
        ev_plain(8'h10);
        for (int i = 0; i < 9; i++) ev_plain(8'(8'h20 + i));
        ev_wend();
        settle();
        chk("R4 err_ovf", int'(err_ovf), 1);
        chk("R4 count", last_cnt, RXM);
        chk("R4 done", done_seen - d0, 1);
        rx_at(7, 8'h26, "R4 last stored");

        // R6 no-op when nothing posted
        ev_start(ADDR);
        ev_plain(8'h01);
        expect_rsp(8'h02, "R6 noop len");
        ev_rdfirst();
        expect_rsp(8'h07, "R6 noop b0");
        ev_rd();
        expect_rsp(8'h02, "R6 noop b1");
        ev_rd();
        ev_rend();
        settle();
        drain("R6 all noop bytes seen");
        chk("R6 req_n idle", int'(req_n), 1);

        // R5 / R7 posted message
        wr(0, 8'h11); wr(1, 8'h22); wr(2, 8'h33);
        post(3);
        settle();
        chk("R7 req_n low after post", int'(req_n), 0);
        chk("R5 pending", int'(tx_pending), 1);
        ev_start(ADDR);
        ev_plain(8'h01);
        expect_rsp(8'h03, "R5 len");
        ev_rdfirst();
        settle();
        chk("R7 req_n released", int'(req_n), 1);
        expect_rsp(8'h11, "R5 p0"); ev_rd();
        expect_rsp(8'h22, "R5 p1"); ev_rd();
        expect_rsp(8'h33, "R5 p2"); ev_rd();
        ev_rend();
        settle();
        drain("R5 all bytes seen");
        chk("R5 pending cleared", int'(tx_pending), 0);

        // R8 premature end and resend
        wr(0, 8'h44); wr(1, 8'h55);
        post(2);
        ev_start(ADDR);
        ev_plain(8'h01);
        expect_rsp(8'h02, "R8 len"); ev_rdfirst();
        expect_rsp(8'h44, "R8 p0");  ev_rd();
        ev_rend();
        settle();
        chk("R8 req_n relowered", int'(req_n), 0);
        chk("R8 still pending", int'(tx_pending), 1);
        ev_start(ADDR);
        ev_plain(8'h01);
        expect_rsp(8'h02, "R8 resend len"); ev_rdfirst();
        expect_rsp(8'h44, "R8 resend p0");  ev_rd();
        expect_rsp(8'h55, "R8 resend p1");  ev_rd();
        ev_rend();
        settle();
        drain("R8 resend complete");
        chk("R8 pending cleared", int'(tx_pending), 0);

        // R14 writes and posts ignored while pending
        wr(0, 8'h77);
        post(1);
        wr(0, 8'h99);
        post(2);
        ev_start(ADDR);
        ev_plain(8'h01);
        expect_rsp(8'h01, "R14 len kept"); ev_rdfirst();
        expect_rsp(8'h77, "R14 byte kept"); ev_rd();
        ev_rend();
        settle();
        drain("R14 sequence");
        chk("R14 pending cleared", int'(tx_pending), 0);

        // R9 underflow
        ev_start(ADDR);
        ev_plain(8'h01);
        expect_rsp(8'h02, "R9 len"); ev_rdfirst();
        expect_rsp(8'h07, "R9 b0");  ev_rd();
        expect_rsp(8'h02, "R9 b1");  ev_rd();
        expect_rsp(8'hFF, "R9 fill"); ev_rd();
        settle();
        drain("R9 responses");
        chk("R9 err_udf", int'(err_udf), 1);
        chk("R10 err_flag clean before", int'(err_flag), 0);

        // R10 turnaround after a non-read command
        d0 = done_seen;
        ev_start(ADDR);
        ev_plain(8'h05);
        expect_rsp(8'hFF, "R10 fill"); ev_rdfirst();
        ev_plain(8'h12);
        ev_wend();
        settle();
        drain("R10 responses");
        chk("R10 err_flag", int'(err_flag), 1);
        chk("R10 no done", done_seen - d0, 0);

        // R11 bad flags in expect-command
        do_reset();
        settle();
        chk("R1 err_flag cleared", int'(err_flag), 0);
        d0 = done_seen;
        ev_start(ADDR);
        ev_wend();
        ev_plain(8'h33);
        ev_wend();
        settle();
        chk("R11 err_flag", int'(err_flag), 1);
        chk("R11 no done", done_seen - d0, 0);
        drain("R11 no responses");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule